// File: doc/BRIEF.md
# Tagged Message Byte Queue for a Serial Link Transmitter

This block buffers outgoing message bytes between a host register interface and a serial link transmitter that does the framing. The host queues each byte through one of two write ports that differ only in the address used. A plain write queues an ordinary byte. A write to the second address queues a byte that closes its message. Each stored entry keeps the byte together with a one-bit end-of-message tag, so several complete messages of any length can wait in the queue behind one another.

The transmitter pulls entries over a valid/ready stream. It also reports, with a one-cycle pulse, when it has sent the closing flag of a message. The block gives the host fill-level status: empty, full, and near-empty against a programmable level. It also keeps two sticky event bits. One records that the transmitter starved in the middle of a message. The other records that a message finished going out. Reading the status clears both sticky bits. The single interrupt output combines the near-empty level and the two sticky bits, each through its own enable bit. With all enables low, the host works by polling.

Back-pressure rules: `tx_valid` is high whenever the queue holds an entry. An entry leaves only in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values. The write side has no ready signal. The host must consult `sts_full`, because the block drops writes made while the queue is full.

Top module: `dlink_tx_queue`

## Requirements
- R1: A write with `wr_last`=0 stores the byte with tag 0. A write with `wr_last`=1 stores it with tag 1. Each byte comes out on `tx_data` with its tag on `tx_last`.
- R2: While `tx_valid`=1 and `tx_ready`=0, the head entry stays on `tx_data`/`tx_last` and `tx_valid` stays high.
- R3: `sts_full`=1 exactly when DEPTH entries are stored. A write made while full is dropped and leaves the stored entries and their order unchanged.
- R4: `sts_empty`=1 exactly when no entry is stored, and `tx_valid` equals the inverse of `sts_empty`.
- R5: `sts_near_empty`=1 exactly when the number of stored entries is less than or equal to `ne_level`.
- R6: `sts_underrun` becomes 1 after a clock edge at which `tx_ready`=1, the queue is empty, and the most recently delivered byte had tag 0. It never sets while the last delivered byte had tag 1, or while no byte has been delivered since reset.
- R7: A one-cycle pulse on `tx_closed` sets `sts_msg_done` from the next cycle on.
- R8: A `stat_rd` pulse clears `sts_underrun` and `sts_msg_done` at the next edge. An event that sets a bit in the same cycle as the read takes priority, and the bit stays 1.
- R9: `irq` = (`irq_en`[0] & `sts_near_empty`) | (`irq_en`[1] & `sts_underrun`) | (`irq_en`[2] & `sts_msg_done`). With `irq_en`=0, `irq` stays 0.
- R10: After reset: `sts_empty`=1, `sts_full`=0, `tx_valid`=0, and `sts_underrun`=`sts_msg_done`=0.
- R11: Bytes leave in write order across message boundaries. A message may start in the write directly after a tagged byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_last | input | 1 | Address select: 1 marks the byte as end of message |
| wr_data | input | 8 | Byte to queue |
| ne_level | input | $clog2(DEPTH+1) | Near-empty level |
| irq_en | input | 3 | Interrupt enables: [0] near-empty, [1] underrun, [2] message done |
| stat_rd | input | 1 | Status read strobe; clears the sticky bits |
| tx_valid | output | 1 | Head entry available |
| tx_ready | input | 1 | Transmitter takes the head entry / wants a byte |
| tx_data | output | 8 | Head byte |
| tx_last | output | 1 | Head byte's end-of-message tag |
| tx_closed | input | 1 | Pulse: closing flag of a message has been sent |
| sts_empty | output | 1 | Queue empty |
| sts_full | output | 1 | Queue full |
| sts_near_empty | output | 1 | Fill at or below `ne_level` |
| sts_underrun | output | 1 | Sticky: transmitter starved mid-message |
| sts_msg_done | output | 1 | Sticky: message completely sent |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the queue with DEPTH=8. At this size, every fill level from 1 to full can be swept. At each level, the near-empty flag is compared against every possible `ne_level` value, 0 through 8, and each fill is drained and compared byte by byte with its tags. The small depth also makes the full boundary and the dropped overflow write cheap to reach on every pass. The three interrupt enables are swept through all eight combinations in two status states.

// File: rtl/dlq_pkg.sv
package dlq_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              eom;
    logic [BYTE_W-1:0] byte_q;
  } dlq_entry_t;

  typedef enum logic [1:0] {
    IRQ_NEAR  = 2'd0,
    IRQ_UNDER = 2'd1,
    IRQ_DONE  = 2'd2
  } irq_src_e;
endpackage

// File: rtl/dlq_store.sv
module dlq_store
  import dlq_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  dlq_entry_t    push_ent,
  input  logic          pop_ready,
  output logic          out_valid,
  output dlq_entry_t    out_ent,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  dlq_entry_t    mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);
  assign out_valid = !empty;
  assign out_ent   = mem[rd_ptr];
  assign count     = cnt;
  assign do_push   = push && !full;
  assign do_pop    = out_valid && pop_ready;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R3: a dropped write leaves the fill level untouched
  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop_ready) |=> (full && $stable(cnt)));

  // R3: fill never exceeds capacity
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R2: head held under back-pressure
  p_hold_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pop_ready) |=> (out_valid && $stable(out_ent)));
endmodule

// File: rtl/dlq_status.sv
module dlq_status
  import dlq_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] ne_level,
  input  logic          pop,
  input  logic          pop_eom,
  input  logic          tx_ready,
  input  logic          tx_valid,
  input  logic          tx_closed,
  input  logic          stat_rd,
  input  logic [2:0]    irq_en,
  output logic          near_empty,
  output logic          underrun,
  output logic          msg_done,
  output logic          irq
);
  logic mid_msg;
  logic ur_evt;
  logic [2:0] src;

  assign near_empty = (count <= ne_level);
  assign ur_evt     = tx_ready && !tx_valid && mid_msg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mid_msg  <= 1'b0;
      underrun <= 1'b0;
      msg_done <= 1'b0;
    end else begin
      if (pop) mid_msg <= !pop_eom;
      underrun <= ur_evt    | (underrun && !stat_rd);
      msg_done <= tx_closed | (msg_done && !stat_rd);
    end
  end

  always_comb begin
    src            = '0;
    src[IRQ_NEAR]  = near_empty;
    src[IRQ_UNDER] = underrun;
    src[IRQ_DONE]  = msg_done;
  end

  assign irq = |(src & irq_en);

  // R6: starvation mid-message is recorded
  p_ur_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ur_evt |=> underrun);

  // R7: closing-flag report is recorded
  p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_closed |=> msg_done);

  // R8: read clears when no new event arrives
  p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !tx_closed) |=> !msg_done);
endmodule

// File: rtl/dlink_tx_queue.sv
module dlink_tx_queue
  import dlq_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_last,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [CW-1:0]     ne_level,
  input  logic [2:0]        irq_en,
  input  logic              stat_rd,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_last,
  input  logic              tx_closed,
  output logic              sts_empty,
  output logic              sts_full,
  output logic              sts_near_empty,
  output logic              sts_underrun,
  output logic              sts_msg_done,
  output logic              irq
);
  dlq_entry_t    in_ent, head;
  logic [CW-1:0] fill;

  assign in_ent.eom    = wr_last;
  assign in_ent.byte_q = wr_data;
  assign tx_data       = head.byte_q;
  assign tx_last       = head.eom;

  dlq_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_en),
    .push_ent  (in_ent),
    .pop_ready (tx_ready),
    .out_valid (tx_valid),
    .out_ent   (head),
    .count     (fill),
    .full      (sts_full),
    .empty     (sts_empty)
  );

  dlq_status #(.CW(CW)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .count      (fill),
    .ne_level   (ne_level),
    .pop        (tx_valid && tx_ready),
    .pop_eom    (head.eom),
    .tx_ready   (tx_ready),
    .tx_valid   (tx_valid),
    .tx_closed  (tx_closed),
    .stat_rd    (stat_rd),
    .irq_en     (irq_en),
    .near_empty (sts_near_empty),
    .underrun   (sts_underrun),
    .msg_done   (sts_msg_done),
    .irq        (irq)
  );

  // R9: no interrupt with every source disabled
  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 3'b000) |-> !irq);

  // R1: a tagged write into an empty queue surfaces as a tagged head
  p_tag_head_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_last && sts_empty) |=> (tx_valid && tx_last));

  // R4: stream valid mirrors the empty flag
  p_valid_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid == !sts_empty);
endmodule

// File: tb/dlink_tx_queue_test.sv
module dlink_tx_queue_test;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, wr_en, wr_last, stat_rd, tx_ready, tx_closed;
  logic [7:0]    wr_data, tx_data;
  logic [CW-1:0] ne_level;
  logic [2:0]    irq_en;
  logic tx_valid, tx_last, sts_empty, sts_full, sts_near_empty;
  logic sts_underrun, sts_msg_done, irq;

  dlink_tx_queue #(.DEPTH(DEPTH)) uut (.*);

  int  vecs = 0;
  int  bad  = 0;
  bit  done = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic last, input logic [7:0] d);
    wr_en = 1'b1; wr_last = last; wr_data = d;
    tick();
    wr_en = 1'b0; wr_last = 1'b0;
  endtask

  function automatic logic [7:0] pat(int k, int i);
    return 8'((k * 16 + i) ^ 8'h5A);
  endfunction

  function automatic logic tagv(int k, int i);
    return (i == k - 1) || (i % 3 == 2);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; vecs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_last = 0; wr_data = 0; stat_rd = 0;
    tx_ready = 0; tx_closed = 0; ne_level = '0; irq_en = 3'b000;
    @(negedge clk);
    tick(); tick();
    rst_n = 1;
    tick();

    // R10 reset state
    check("R10 empty", sts_empty, 1);
    check("R10 full", sts_full, 0);
    check("R10 valid", tx_valid, 0);
    check("R10 underrun", sts_underrun, 0);
    check("R10 msg_done", sts_msg_done, 0);
    check("R9 irq off", irq, 0);

    // fill sweep: R1 R3 R4 R5 R11
    for (int k = 1; k <= DEPTH; k++) begin
      for (int i = 0; i < k; i++) begin
        push(tagv(k, i), pat(k, i));
        check("R4 empty", sts_empty, 0);
        check("R4 valid", tx_valid, 1);
        check("R3 full", sts_full, (i + 1 == DEPTH));
        for (int th = 0; th <= DEPTH; th++) begin
          ne_level = CW'(th);
          #1;
          check("R5 near_empty", sts_near_empty, (i + 1 <= th));
        end
      end
      if (k == DEPTH) begin
        push(1'b1, 8'hEE);
        check("R3 full after drop", sts_full, 1);
      end
      tx_ready = 1'b1;
      for (int i = 0; i < k; i++) begin
        check("R11 order data", tx_data, pat(k, i));
        check("R1 tag", tx_last, tagv(k, i));
        tick();
      end
      tx_ready = 1'b0;
      check("R4 empty after drain", sts_empty, 1);
      check("R6 no underrun after EOM", sts_underrun, 0);
    end

    // R2 back-pressure
    push(1'b0, 8'hA1); push(1'b0, 8'hA2); push(1'b1, 8'hA3);
    for (int c = 0; c < 4; c++) begin
      tick();
      check("R2 hold data", tx_data, 8'hA1);
      check("R2 hold valid", tx_valid, 1);
    end
    tx_ready = 1'b1;
    tick(); tick(); tick();
    tx_ready = 1'b0;

    // R6 underrun mid-message
    ne_level = '0;
    irq_en = 3'b010;
    push(1'b0, 8'h11); push(1'b0, 8'h12);
    tx_ready = 1'b1;
    tick(); tick();
    check("R6 not yet", sts_underrun, 0);
    tick();
    tx_ready = 1'b0;
    check("R6 underrun set", sts_underrun, 1);
    check("R9 irq underrun", irq, 1);
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    check("R8 underrun cleared", sts_underrun, 0);
    check("R9 irq cleared", irq, 0);
    push(1'b1, 8'h13);
    tx_ready = 1'b1;
    tick(); tick(); tick();
    tx_ready = 1'b0;
    check("R6 no underrun after EOM", sts_underrun, 0);

    // R7 R8 message done
    irq_en = 3'b100;
    tx_closed = 1'b1; tick(); tx_closed = 1'b0;
    check("R7 msg_done", sts_msg_done, 1);
    check("R9 irq done", irq, 1);
    stat_rd = 1'b1; tx_closed = 1'b1; tick(); stat_rd = 1'b0; tx_closed = 1'b0;
    check("R8 set wins", sts_msg_done, 1);
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    check("R8 msg_done cleared", sts_msg_done, 0);

    // R9 enable sweep, near-empty high
    push(1'b0, 8'h21);
    tx_ready = 1'b1; tick(); tick(); tx_ready = 1'b0;
    tx_closed = 1'b1; tick(); tx_closed = 1'b0;
    for (int e = 0; e < 8; e++) begin
      irq_en = 3'(e);
      #1;
      check("R9 irq all set", irq, (e != 0));
    end
    // near-empty low, only msg_done set
    irq_en = 3'b000;
    push(1'b1, 8'h22);
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    tx_closed = 1'b1; tick(); tx_closed = 1'b0;
    for (int e = 0; e < 8; e++) begin
      irq_en = 3'(e);
      #1;
      check("R9 irq done only", irq, (e >= 4));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule